// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Sequencer

This block keeps an asynchronous DRAM with a 2048-row refresh counter alive. After reset it holds the memory quiet for a power-up pause. It then runs a fixed number of warm-up refresh cycles and only after that raises `init_done`, which the memory controller treats as its ready signal. In normal operation a free-running interval timer adds one owed refresh per refresh slot. The default of 780 cycles at 50 MHz gives 15.6 µs, so all 2048 rows are covered in 32 ms. Every refresh uses the CAS-before-RAS order, so the device supplies the row address and no address pins are driven.

The sequencer shares the memory strobes with a host controller through a plain request/grant pair. It raises `ref_req`, waits for `ref_gnt`, and drives `ras_n`, `cas_n` and `we_n` while it holds the bus. Owed refreshes are counted by a credit counter that saturates at `CREDIT_MAX`. When the bus is granted, all owed cycles run back to back. The `BURST_MODE` parameter selects the policy:
- **Distributed:** the bus is requested as soon as one refresh is owed.
- **Burst:** the bus is requested only when the credit counter is full.

A low-power request places the memory in self refresh. The block holds both strobes low for a minimum time, then observes a recovery precharge on exit. All timings are parameters counted in clock cycles.

States:
- `ST_PAUSE`: power-up wait.
- `ST_IDLE`: nothing owed.
- `ST_WAIT_BUS`: request raised, waiting for grant.
- `ST_CAS_LEAD`: CAS low ahead of RAS.
- `ST_RAS_ACTIVE`: RAS low.
- `ST_PRECHARGE`: both strobes high.
- `ST_SELF_WAIT`: waiting for grant before self refresh.
- `ST_SELF_LEAD`: CAS low ahead of RAS for self refresh.
- `ST_SELF_HOLD`: self refresh.
- `ST_SELF_RECOVER`: exit precharge.

Transitions:

| From | To | Condition |
|---|---|---|
| PAUSE | IDLE | pause count elapsed |
| IDLE | WAIT_BUS | warm-up incomplete, or refresh owed under the active policy |
| IDLE | SELF_WAIT | `self_req` set, nothing owed, ready |
| WAIT_BUS | CAS_LEAD | `ref_gnt` set |
| CAS_LEAD | RAS_ACTIVE | lead time elapsed |
| RAS_ACTIVE | PRECHARGE | RAS width elapsed |
| PRECHARGE | CAS_LEAD | more owed and `ref_gnt` set |
| PRECHARGE | WAIT_BUS | more owed, no grant |
| PRECHARGE | IDLE | nothing owed |
| SELF_WAIT | SELF_LEAD | grant |
| SELF_WAIT | IDLE | request withdrawn |
| SELF_LEAD | SELF_HOLD | lead time elapsed |
| SELF_HOLD | SELF_RECOVER | request withdrawn and minimum hold met |
| SELF_RECOVER | IDLE | recovery elapsed |

Top module: `dram_refresh_seq`

## Requirements
- R1: During and directly after reset, the outputs are: `ras_n`, `cas_n` and `we_n` high; `ref_req` low; `init_done` low; `self_active` low.
- R2: For the first `PAUSE_CYC` cycles after reset, `ref_req` stays low and no RAS falling edge occurs.
- R3: After the pause, exactly `WARMUP_CYC` refresh cycles occur before `init_done` rises. Once high, `init_done` stays high until reset.
- R4: Every RAS falling edge follows at least `CSR_CYC` cycles of CAS low. CAS is still low in the first RAS-low cycle. `we_n` is high at every RAS falling edge.
- R5: In a refresh cycle, RAS stays low for exactly `RAS_CYC` cycles. RAS stays high for at least `RP_CYC` cycles before it falls again.
- R6: In distributed mode with the bus always granted, successive refresh cycles start exactly `INTERVAL_CYC` cycles apart.
- R7: The strobes are driven low only while `ref_req` is high, and no cycle starts without `ref_gnt`. While a refresh is owed and no grant is given, `ref_req` stays high and no strobe moves.
- R8: Owed refreshes accumulate up to `CREDIT_MAX` while the grant is withheld; further slots are dropped. On grant, all owed cycles run back to back, with RAS falling edges `CSR_CYC+RAS_CYC+RP_CYC` cycles apart.
- R9: In burst mode, no refresh is requested until `CREDIT_MAX` are owed. Then exactly `CREDIT_MAX` cycles run back to back.
- R10: A `self_req` while ready and idle, once granted, takes CAS low and then RAS low, and raises `self_active`. Both strobes stay low while `self_req` is held, and for no fewer than `RASS_CYC` cycles.
- R11: On self refresh exit, RAS and CAS stay high for `RPS_CYC` cycles. Refresh slots that elapse during self refresh are not owed afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Bus granted to the sequencer by the arbiter |
| self_req | input | 1 | Request to hold the memory in self refresh |
| ref_req | output | 1 | Sequencer asks for, or holds, the bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low; held high |
| init_done | output | 1 | Power-up pause and warm-up complete |
| self_active | output | 1 | Memory is in self refresh |

## Verification
The bench withholds the grant for one, three, eight and eleven refresh slots. A counter that fails to saturate would give eleven cycles instead of eight. A sequencer that idles between owed cycles would show a wider spacing than the back-to-back period. The exact count of warm-up cycles before ready is checked, as is the burst instance's silence until the credit counter is full. A design that issued refreshes during the pause, or one that raised ready early, would be caught. Self refresh is dropped before its minimum hold and must stay low for exactly that time. It is also held across several slots, and a design that banked those slots would fire a burst of refreshes on exit.

// File: rtl/drs_pkg.sv
package drs_pkg;

    typedef enum logic [3:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_WAIT_BUS,
        ST_CAS_LEAD,
        ST_RAS_ACTIVE,
        ST_PRECHARGE,
        ST_SELF_WAIT,
        ST_SELF_LEAD,
        ST_SELF_HOLD,
        ST_SELF_RECOVER
    } seq_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/drs_tick.sv
module drs_tick #(
    parameter int unsigned PERIOD = 780
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(PERIOD - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/drs_credit.sv
module drs_credit #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    input  logic clr,
    output logic nonzero,
    output logic full
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
                2'b01:   if (cnt != '0) cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign nonzero = (cnt != '0);
    assign full    = (cnt == CW'(LIMIT));
endmodule

// File: rtl/drs_fsm.sv
module drs_fsm
    import drs_pkg::*;
#(
    parameter int unsigned PAUSE_CYC  = 10000,
    parameter int unsigned WARMUP_CYC = 8,
    parameter int unsigned CSR_CYC    = 1,
    parameter int unsigned CHR_CYC    = 1,
    parameter int unsigned RAS_CYC    = 3,
    parameter int unsigned RP_CYC     = 2,
    parameter int unsigned RASS_CYC   = 5000,
    parameter int unsigned RPS_CYC    = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    input  logic self_req,
    input  logic start_ok,
    input  logic more_ok,
    output logic ref_req,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic init_done,
    output logic self_active,
    output logic consume,
    output logic accrue_en,
    output logic credit_clr
);
    localparam int unsigned SPAN = max_u(max_u(max_u(PAUSE_CYC, RASS_CYC), max_u(RPS_CYC, RAS_CYC)),
                                         max_u(max_u(RP_CYC, CSR_CYC), CHR_CYC));
    localparam int unsigned PH_W = $clog2(SPAN + 1);
    localparam logic [PH_W-1:0] PH_MAX = '1;
    localparam int unsigned WM_W = $clog2(WARMUP_CYC + 1);

    seq_state_e        state, nxt;
    logic [PH_W-1:0]   ph;
    logic [WM_W-1:0]   warm;
    logic              warm_done, ras_end, want_start, want_more;

    assign warm_done  = (warm == WM_W'(WARMUP_CYC));
    assign ras_end    = (state == ST_RAS_ACTIVE) && (ph == PH_W'(RAS_CYC - 1));
    assign want_start = !warm_done || start_ok;
    assign want_more  = !warm_done || more_ok;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_PAUSE:        if (ph == PH_W'(PAUSE_CYC - 1)) nxt = ST_IDLE;
            ST_IDLE:         if (want_start) nxt = ST_WAIT_BUS;
                             else if (self_req && warm_done) nxt = ST_SELF_WAIT;
            ST_WAIT_BUS:     if (ref_gnt) nxt = ST_CAS_LEAD;
            ST_CAS_LEAD:     if (ph == PH_W'(CSR_CYC - 1)) nxt = ST_RAS_ACTIVE;
            ST_RAS_ACTIVE:   if (ras_end) nxt = ST_PRECHARGE;
            ST_PRECHARGE:    if (ph == PH_W'(RP_CYC - 1)) begin
                                 if (!want_more) nxt = ST_IDLE;
                                 else if (ref_gnt) nxt = ST_CAS_LEAD;
                                 else nxt = ST_WAIT_BUS;
                             end
            ST_SELF_WAIT:    if (!self_req) nxt = ST_IDLE;
                             else if (ref_gnt) nxt = ST_SELF_LEAD;
            ST_SELF_LEAD:    if (ph == PH_W'(CSR_CYC - 1)) nxt = ST_SELF_HOLD;
            ST_SELF_HOLD:    if (!self_req && ph >= PH_W'(RASS_CYC - 1)) nxt = ST_SELF_RECOVER;
            ST_SELF_RECOVER: if (ph == PH_W'(RPS_CYC - 1)) nxt = ST_IDLE;
            default:         nxt = ST_PAUSE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PAUSE;
            ph    <= '0;
            warm  <= '0;
        end else begin
            state <= nxt;
            if (nxt != state)     ph <= '0;
            else if (ph != PH_MAX) ph <= ph + 1'b1;
            if (ras_end && !warm_done) warm <= warm + 1'b1;
        end
    end

    always_comb begin
        ref_req     = 1'b1;
        ras_n       = 1'b1;
        cas_n       = 1'b1;
        we_n        = 1'b1;
        self_active = 1'b0;
        accrue_en   = warm_done;
        credit_clr  = 1'b0;
        unique case (state)
            ST_PAUSE, ST_IDLE: ref_req = 1'b0;
            ST_CAS_LEAD:       cas_n = 1'b0;
            ST_RAS_ACTIVE: begin
                ras_n = 1'b0;
                cas_n = !(ph < PH_W'(CHR_CYC));
            end
            ST_SELF_LEAD: begin
                cas_n     = 1'b0;
                accrue_en = 1'b0;
            end
            ST_SELF_HOLD: begin
                ras_n       = 1'b0;
                cas_n       = 1'b0;
                self_active = 1'b1;
                accrue_en   = 1'b0;
                credit_clr  = 1'b1;
            end
            ST_SELF_RECOVER:   accrue_en = 1'b0;
            default:           ref_req = 1'b1;
        endcase
    end

    assign init_done = warm_done;
    assign consume   = ras_end && warm_done;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
    parameter int unsigned PAUSE_CYC    = 10000,
    parameter int unsigned WARMUP_CYC   = 8,
    parameter int unsigned INTERVAL_CYC = 780,
    parameter int unsigned CREDIT_MAX   = 8,
    parameter bit          BURST_MODE   = 1'b0,
    parameter int unsigned CSR_CYC      = 1,
    parameter int unsigned CHR_CYC      = 1,
    parameter int unsigned RAS_CYC      = 3,
    parameter int unsigned RP_CYC       = 2,
    parameter int unsigned RASS_CYC     = 5000,
    parameter int unsigned RPS_CYC      = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_gnt,
    input  logic self_req,
    output logic ref_req,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic init_done,
    output logic self_active
);
    logic slot_tick, owed_any, owed_full, start_ok;
    logic consume, accrue_en, credit_clr;

    drs_tick #(.PERIOD(INTERVAL_CYC)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (slot_tick)
    );

    drs_credit #(.LIMIT(CREDIT_MAX)) u_credit (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (slot_tick && accrue_en),
        .dec    (consume),
        .clr    (credit_clr),
        .nonzero(owed_any),
        .full   (owed_full)
    );

    generate
        if (BURST_MODE) begin : g_burst
            assign start_ok = owed_full;
        end else begin : g_spread
            assign start_ok = owed_any;
        end
    endgenerate

    drs_fsm #(
        .PAUSE_CYC (PAUSE_CYC),
        .WARMUP_CYC(WARMUP_CYC),
        .CSR_CYC   (CSR_CYC),
        .CHR_CYC   (CHR_CYC),
        .RAS_CYC   (RAS_CYC),
        .RP_CYC    (RP_CYC),
        .RASS_CYC  (RASS_CYC),
        .RPS_CYC   (RPS_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_gnt    (ref_gnt),
        .self_req   (self_req),
        .start_ok   (start_ok),
        .more_ok    (owed_any),
        .ref_req    (ref_req),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .init_done  (init_done),
        .self_active(self_active),
        .consume    (consume),
        .accrue_en  (accrue_en),
        .credit_clr (credit_clr)
    );
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_gnt,
    input logic ref_req,
    input logic ras_n,
    input logic cas_n,
    input logic init_done,
    input logic self_active
);
    p_cas_leads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n));

    p_cas_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> !cas_n);

    p_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> ras_n);

    p_start_on_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(ref_gnt));

    p_strobe_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> ref_req);

    p_ready_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_self_after_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        self_active |-> (init_done && !ras_n && !cas_n));
endmodule

bind dram_refresh_seq dram_refresh_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_gnt    (ref_gnt),
    .ref_req    (ref_req),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .init_done  (init_done),
    .self_active(self_active)
);

// File: tb/dram_refresh_seq_test.sv
`timescale 1ns/1ps
module dram_refresh_seq_test;
    localparam int PAUSE  = 200;
    localparam int WARM   = 8;
    localparam int INTV   = 100;
    localparam int CMAX   = 8;
    localparam int CSR    = 1;
    localparam int CHR    = 1;
    localparam int RASW   = 3;
    localparam int RP     = 2;
    localparam int RASS   = 50;
    localparam int RPS    = 6;
    localparam int B2B    = CSR + RASW + RP;

    // withheld slots, expected back-to-back cycles on grant
    localparam int NVEC = 4;
    localparam int VEC [NVEC][2] = '{'{1, 1}, '{3, 3}, '{8, 8}, '{11, 8}};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, gnt = 1'b1, self_req = 1'b0;
    logic ref_req, ras_n, cas_n, we_n, init_done, self_active;
    logic req_b, ras_b, cas_b, we_b, done_b, self_b;

    dram_refresh_seq #(.PAUSE_CYC(PAUSE), .WARMUP_CYC(WARM), .INTERVAL_CYC(INTV),
        .CREDIT_MAX(CMAX), .BURST_MODE(1'b0), .CSR_CYC(CSR), .CHR_CYC(CHR),
        .RAS_CYC(RASW), .RP_CYC(RP), .RASS_CYC(RASS), .RPS_CYC(RPS)) uut (
        .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .self_req(self_req),
        .ref_req(ref_req), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .init_done(init_done), .self_active(self_active));

    dram_refresh_seq #(.PAUSE_CYC(PAUSE), .WARMUP_CYC(WARM), .INTERVAL_CYC(INTV),
        .CREDIT_MAX(CMAX), .BURST_MODE(1'b1), .CSR_CYC(CSR), .CHR_CYC(CHR),
        .RAS_CYC(RASW), .RP_CYC(RP), .RASS_CYC(RASS), .RPS_CYC(RPS)) uut_burst (
        .clk(clk), .rst_n(rst_n), .ref_gnt(1'b1), .self_req(1'b0),
        .ref_req(req_b), .ras_n(ras_b), .cas_n(cas_b), .we_n(we_b),
        .init_done(done_b), .self_active(self_b));

    int checks = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // port monitors, sampled at the falling clock edge
    int fall_cnt = 0, last_fall = 0, prev_fall = 0, last_rise = 0, low_start = 0, last_low = 0;
    logic ras_q = 1'b1, cas_q = 1'b1, self_q = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ras_q && !ras_n) begin
                fall_cnt++;
                prev_fall = last_fall;
                last_fall = cyc;
                low_start = cyc;
                chk(!cas_n && !cas_q, "R4 cas low before and at ras fall", {cas_q, cas_n}, 0);
                chk(we_n == 1'b1, "R4 we high at ras fall", we_n, 1);
                chk(cyc - last_rise >= RP, "R5 ras precharge", cyc - last_rise, RP);
            end
            if (!ras_q && ras_n) begin
                last_rise = cyc;
                last_low  = cyc - low_start;
                if (!self_q) chk(last_low == RASW, "R5 ras low width", last_low, RASW);
            end
        end
        ras_q  = ras_n;
        cas_q  = cas_n;
        self_q = self_active;
    end

    int fall_b = 0, last_fall_b = 0, prev_fall_b = 0;
    logic ras_bq = 1'b1;
    always @(negedge clk) begin
        if (rst_n && ras_bq && !ras_b) begin
            fall_b++;
            prev_fall_b = last_fall_b;
            last_fall_b = cyc;
        end
        ras_bq = ras_b;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        finish_run();
    end

    task automatic sync_after_refresh();
        int cur;
        cur = fall_cnt;
        for (int i = 0; i < 400 && fall_cnt == cur; i++) step();
        for (int i = 0; i < 60 && ref_req; i++) step();
    endtask

    initial begin
        int base, t_init, t0;
        bit ok;
        repeat (4) step();
        // R1 reset values
        chk(ras_n == 1'b1, "R1 ras_n in reset", ras_n, 1);
        chk(cas_n == 1'b1, "R1 cas_n in reset", cas_n, 1);
        chk(we_n == 1'b1, "R1 we_n in reset", we_n, 1);
        chk(ref_req == 1'b0, "R1 ref_req in reset", ref_req, 0);
        chk(init_done == 1'b0, "R1 init_done in reset", init_done, 0);
        chk(self_active == 1'b0, "R1 self_active in reset", self_active, 0);
        rst_n = 1'b1;
        step();
        chk(ras_n && cas_n && !ref_req && !init_done, "R1 state after release",
            {ras_n, cas_n, ref_req, init_done}, 4'b1100);

        // R2 quiet pause
        repeat (PAUSE - 3) step();
        chk(!ref_req && fall_cnt == 0, "R2 quiet during pause", fall_cnt + ref_req, 0);

        // R3 warm-up then ready
        for (int i = 0; i < 400 && !init_done; i++) step();
        t_init = cyc;
        chk(fall_cnt == WARM, "R3 warm-up cycle count", fall_cnt, WARM);
        chk(last_fall - prev_fall == B2B, "R3 warm-up back to back", last_fall - prev_fall, B2B);
        chk(fall_b == WARM && done_b, "R9 burst instance warm-up", fall_b, WARM);

        // R9 burst policy
        base = fall_b;
        for (int i = 0; i < 1500 && fall_b == base; i++) step();
        t0 = cyc;
        chk(t0 - t_init >= (CMAX - 2) * INTV, "R9 burst waits for full credit", t0 - t_init, (CMAX - 2) * INTV);
        repeat (70) step();
        chk(fall_b - base == CMAX, "R9 burst drains all owed", fall_b - base, CMAX);
        chk(last_fall_b - prev_fall_b == B2B, "R9 burst spacing", last_fall_b - prev_fall_b, B2B);

        // R6 distributed spacing
        chk(init_done == 1'b1, "R3 ready held", init_done, 1);
        base = fall_cnt;
        for (int i = 0; i < 400 && fall_cnt < base + 2; i++) step();
        chk(last_fall - prev_fall == INTV, "R6 distributed spacing", last_fall - prev_fall, INTV);

        // R7/R8 table: withhold the grant for N slots
        for (int v = 0; v < NVEC; v++) begin
            sync_after_refresh();
            gnt  = 1'b0;
            base = fall_cnt;
            repeat (VEC[v][0] * INTV) step();
            chk(fall_cnt == base, "R7 no strobe without grant", fall_cnt - base, 0);
            chk(ref_req == 1'b1, "R7 request held while owed", ref_req, 1);
            gnt = 1'b1;
            repeat (70) step();
            chk(fall_cnt - base == VEC[v][1], "R8 owed cycles issued", fall_cnt - base, VEC[v][1]);
            if (VEC[v][1] > 1)
                chk(last_fall - prev_fall == B2B, "R8 back to back spacing", last_fall - prev_fall, B2B);
        end

        // R10 short self refresh, dropped before minimum
        sync_after_refresh();
        self_req = 1'b1;
        for (int i = 0; i < 20 && !self_active; i++) step();
        chk(self_active && !ras_n && !cas_n, "R10 self refresh entered", {self_active, ras_n, cas_n}, 3'b100);
        repeat (5) step();
        self_req = 1'b0;
        for (int i = 0; i < 200 && !ras_n; i++) step();
        chk(last_low == RASS, "R10 minimum self hold", last_low, RASS);
        ok = 1'b1;
        for (int i = 0; i < RPS; i++) begin
            if (!ras_n || !cas_n || self_active) ok = 1'b0;
            step();
        end
        chk(ok, "R11 exit recovery high", ok, 1);

        // R10/R11 long self refresh across several slots
        sync_after_refresh();
        self_req = 1'b1;
        repeat (350) step();
        chk(self_active && !ras_n, "R10 held while requested", {self_active, ras_n}, 2'b10);
        self_req = 1'b0;
        for (int i = 0; i < 100 && !ras_n; i++) step();
        base = fall_cnt;
        repeat (60) step();
        chk(fall_cnt - base <= 1, "R11 slots not owed after self", fall_cnt - base, 0);

        finish_run();
    end
endmodule